// File: doc/BRIEF.md
# SPI Command Frame Decoder

This block is the serial command front end of a multi-channel sensor interface controller. A host talks to it as an SPI mode 0 master. Each frame is 16 bits, MSB first, and is bounded by chip select. The slave oversamples SCLK, chip select and MOSI in the system clock domain. It decodes each received word when chip select rises, and it answers that word during the next frame. Every reply therefore trails its command by exactly one frame. A final NOP frame collects the last reply.

Register writes and reads take several frames. They use a small internal register file of 12-bit values. Commands for sync pulses and sensor data only raise one-cycle strobes for neighbouring logic. A write to register 0 sets the per-channel pulse-length bits that go with the sync strobe. Frames that do not match a legal command are rejected and raise a sticky invalid-command flag. Frames with the wrong number of clocks are discarded. Chip select pulses with no clocks at all are ignored.

The block moves no data stream, so it has no valid/ready handshake. Its outputs are plain level and strobe pins, and the host paces every transfer through chip select.

Top module: `spi_cmd_frontend`

## Requirements
- R1: After hardware reset the first frame returns 0x0000 on MISO and the invalid flag reads 0.
- R2: The reply to the frame received as frame n is shifted out during frame n+1. A NOP (0xE000) is answered with 0xE000.
- R3: A frame is a legal command only if bits [11:0] are zero and bits [15:12] are one of: 0001 write, 0010 read, 0011 sync, 0100/0101/0111/1000 data request, 1110 NOP, 1111 software reset. Any other frame is not executed, sets the invalid flag and makes the next reply 0x0000.
- R4: Write is three frames: 0x1000, then a payload {addr[15:12], data[11:0]}, then a further command. The payload is stored, and the third frame returns {addr, stored value}. The command frame itself is echoed.
- R5: Read is 0x1000-style: 0x2000, then {addr[15:12], 12'h000}, and the following frame returns {addr, register value}. A read payload with nonzero bits [11:0] is treated as an invalid command (R3 handling).
- R6: The frame right after a write payload accepts only write, read, sync, NOP or software reset. A data request there is rejected as in R3, with no strobe.
- R7: A sync command (0x3000) gives a one-cycle sync strobe and is echoed. The pulse-length outputs equal bits [3:0] of register 0, one bit per channel, where 1 means long and 0 means short.
- R8: Data request commands give a one-cycle request strobe and are echoed. The size code is 0 for 0x4000, 1 for 0x5000, 2 for 0x7000 and 3 for 0x8000.
- R9: A frame with between 1 and 15 SCLK rising edges, or more than 16, is a communication error. It is not executed, it aborts any pending sequence, it makes the next reply 0x0000, and it leaves the invalid flag unchanged.
- R10: A chip select pulse with no SCLK edge is ignored. It causes no strobe, and the next frame still returns the reply that was pending.
- R11: Software reset (0xF000) clears all registers and the invalid flag, and makes the next reply 0x0000.
- R12: Address 15 is the status register and reads as {4'hF, 11'b0, invalid flag}. Reading it clears the flag. Writes to it change nothing, and their readback shows the status value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI serial clock from host |
| cs_n_i | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial reply to host |
| sync_pulse_o | output | 1 | One-cycle sync command strobe |
| sync_long_o | output | NCH | Per-channel pulse length, 1 = long |
| data_req_o | output | 1 | One-cycle sensor data request strobe |
| data_size_o | output | 2 | Size code of the last data request |
| err_invalid_o | output | 1 | Sticky invalid-command flag |

## Verification
The hardest cases are frames that break the normal cadence. These include a frame cut short mid-read, a chip select blip with no clocks, and a data request placed right after a write payload, where it is rejected. The bench's frame task takes an explicit bit count, and it has a separate chip-select-only pulse. These let the bench insert such frames between ordinary ones. A trailing full NOP frame then shows, at MISO, which reply the decoder kept pending. The status register's address (0xF000 in the payload slot) has the same bit pattern as a software reset. It is read back to show that payload frames are never decoded as commands.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int FRAME_W = 16;
  localparam int OP_W    = 4;

  typedef enum logic [OP_W-1:0] {
    OP_WRITE = 4'b0001,
    OP_READ  = 4'b0010,
    OP_SYNC  = 4'b0011,
    OP_GET16 = 4'b0100,
    OP_GET24 = 4'b0101,
    OP_GET32 = 4'b0111,
    OP_GET48 = 4'b1000,
    OP_NOP   = 4'b1110,
    OP_SWRST = 4'b1111
  } spi_op_e;

  typedef enum logic [1:0] {
    ST_CMD,
    ST_WR_DATA,
    ST_RD_ADDR,
    ST_WR_NEXT
  } seq_state_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_async,
  output logic [W-1:0] pins_sync
);
  logic [STAGES-1:0][W-1:0] chain_q;

  initial begin
    if (STAGES < 2) $error("spi_pin_sync needs at least two stages");
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], pins_async};
  end

  assign pins_sync = chain_q[STAGES-1];
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               cs_n_s,
  input  logic               mosi_s,
  input  logic [FRAME_W-1:0] reply_i,
  output logic               miso_o,
  output logic               frame_done_o,
  output logic               frame_ok_o,
  output logic [FRAME_W-1:0] frame_word_o
);
  localparam int CNT_W = $clog2(FRAME_W) + 2;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic               sclk_p, cs_n_p;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] rx_q, tx_q;
  logic               sclk_rise, sclk_fall, cs_fall, cs_rise;

  assign sclk_rise = sclk_s & ~sclk_p;
  assign sclk_fall = ~sclk_s & sclk_p;
  assign cs_fall   = ~cs_n_s & cs_n_p;
  assign cs_rise   = cs_n_s & ~cs_n_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p       <= 1'b0;
      cs_n_p       <= 1'b1;
      cnt_q        <= '0;
      rx_q         <= '0;
      tx_q         <= '0;
      miso_o       <= 1'b0;
      frame_done_o <= 1'b0;
      frame_ok_o   <= 1'b0;
      frame_word_o <= '0;
    end else begin
      sclk_p       <= sclk_s;
      cs_n_p       <= cs_n_s;
      frame_done_o <= 1'b0;
      if (cs_fall) begin
        cnt_q  <= '0;
        miso_o <= reply_i[FRAME_W-1];
        tx_q   <= reply_i << 1;
      end else if (!cs_n_s) begin
        if (sclk_rise) begin
          rx_q <= {rx_q[FRAME_W-2:0], mosi_s};
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
        if (sclk_fall) begin
          miso_o <= tx_q[FRAME_W-1];
          tx_q   <= tx_q << 1;
        end
      end
      if (cs_rise && cnt_q != '0) begin
        frame_done_o <= 1'b1;
        frame_ok_o   <= (cnt_q == CNT_FULL);
        frame_word_o <= rx_q;
      end
    end
  end

  assert_done_when_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> cs_n_s);
  assert_clockless_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && cnt_q == '0) |=> !frame_done_o);
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int NCH = 4,
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_done_i,
  input  logic               frame_ok_i,
  input  logic [FRAME_W-1:0] frame_word_i,
  output logic [FRAME_W-1:0] reply_o,
  output logic               sync_pulse_o,
  output logic [NCH-1:0]     sync_long_o,
  output logic               data_req_o,
  output logic [1:0]         data_size_o,
  output logic               err_invalid_o
);
  localparam int DATA_W = FRAME_W - ADDR_W;
  localparam int NREG = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NREG - 1);

  seq_state_e        state_q;
  logic [DATA_W-1:0] regs_q [NREG];
  logic [ADDR_W-1:0] f_addr;
  logic [DATA_W-1:0] f_data, stat_field;
  logic              is_stat, known_op, low_zero, next_ok, cmd_ok;
  spi_op_e           op;

  assign f_addr     = frame_word_i[FRAME_W-1 -: ADDR_W];
  assign f_data     = frame_word_i[DATA_W-1:0];
  assign is_stat    = (f_addr == STAT_ADDR);
  assign stat_field = {{(DATA_W-1){1'b0}}, err_invalid_o};
  assign op         = spi_op_e'(frame_word_i[FRAME_W-1 -: OP_W]);
  assign low_zero   = (frame_word_i[FRAME_W-OP_W-1:0] == '0);

  always_comb begin
    case (op)
      OP_WRITE, OP_READ, OP_SYNC, OP_NOP, OP_SWRST: begin known_op = 1'b1; next_ok = 1'b1; end
      OP_GET16, OP_GET24, OP_GET32, OP_GET48:       begin known_op = 1'b1; next_ok = 1'b0; end
      default:                                      begin known_op = 1'b0; next_ok = 1'b0; end
    endcase
    cmd_ok = known_op && low_zero && (state_q != ST_WR_NEXT || next_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_CMD;
      reply_o       <= '0;
      err_invalid_o <= 1'b0;
      sync_pulse_o  <= 1'b0;
      data_req_o    <= 1'b0;
      data_size_o   <= '0;
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      sync_pulse_o <= 1'b0;
      data_req_o   <= 1'b0;
      if (frame_done_i) begin
        if (!frame_ok_i) begin
          reply_o <= '0;
          state_q <= ST_CMD;
        end else begin
          case (state_q)
            ST_WR_DATA: begin
              if (!is_stat) regs_q[f_addr] <= f_data;
              reply_o <= {f_addr, is_stat ? stat_field : f_data};
              state_q <= ST_WR_NEXT;
            end
            ST_RD_ADDR: begin
              state_q <= ST_CMD;
              if (f_data != '0) begin
                err_invalid_o <= 1'b1;
                reply_o       <= '0;
              end else begin
                reply_o <= {f_addr, is_stat ? stat_field : regs_q[f_addr]};
                if (is_stat) err_invalid_o <= 1'b0;
              end
            end
            default: begin
              state_q <= ST_CMD;
              if (!cmd_ok) begin
                err_invalid_o <= 1'b1;
                reply_o       <= '0;
              end else begin
                reply_o <= frame_word_i;
                case (op)
                  OP_WRITE: state_q <= ST_WR_DATA;
                  OP_READ:  state_q <= ST_RD_ADDR;
                  OP_SYNC:  sync_pulse_o <= 1'b1;
                  OP_GET16: begin data_req_o <= 1'b1; data_size_o <= 2'd0; end
                  OP_GET24: begin data_req_o <= 1'b1; data_size_o <= 2'd1; end
                  OP_GET32: begin data_req_o <= 1'b1; data_size_o <= 2'd2; end
                  OP_GET48: begin data_req_o <= 1'b1; data_size_o <= 2'd3; end
                  OP_SWRST: begin
                    reply_o       <= '0;
                    err_invalid_o <= 1'b0;
                    for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
                  end
                  default: ;
                endcase
              end
            end
          endcase
        end
      end
    end
  end

  assign sync_long_o = regs_q[0][NCH-1:0];

  assert_sync_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse_o |=> !sync_pulse_o);
  assert_req_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_req_o |=> !data_req_o);
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sync_pulse_o, data_req_o}));
  assert_err_after_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_invalid_o) |-> $past(frame_done_i && frame_ok_i));
  assert_commerr_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done_i && !frame_ok_i) |=> (reply_o == '0));
  assert_strobe_from_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pulse_o || data_req_o) |-> $past(frame_done_i && frame_ok_i));
endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
  import spi_cmd_pkg::*;
#(
  parameter int NCH = 4,
  parameter int ADDR_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sclk_i,
  input  logic           cs_n_i,
  input  logic           mosi_i,
  output logic           miso_o,
  output logic           sync_pulse_o,
  output logic [NCH-1:0] sync_long_o,
  output logic           data_req_o,
  output logic [1:0]     data_size_o,
  output logic           err_invalid_o
);
  logic [2:0]         pins_s;
  logic               frame_done, frame_ok;
  logic [FRAME_W-1:0] frame_word, reply;

  spi_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pins_async({cs_n_i, sclk_i, mosi_i}),
    .pins_sync(pins_s)
  );

  spi_shift_engine u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[1]), .cs_n_s(pins_s[2]), .mosi_s(pins_s[0]),
    .reply_i(reply), .miso_o(miso_o),
    .frame_done_o(frame_done), .frame_ok_o(frame_ok), .frame_word_o(frame_word)
  );

  spi_cmd_engine #(.NCH(NCH), .ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .frame_done_i(frame_done), .frame_ok_i(frame_ok), .frame_word_i(frame_word),
    .reply_o(reply), .sync_pulse_o(sync_pulse_o), .sync_long_o(sync_long_o),
    .data_req_o(data_req_o), .data_size_o(data_size_o), .err_invalid_o(err_invalid_o)
  );
endmodule

// File: tb/spi_cmd_frontend_bench.sv
module spi_cmd_frontend_bench;
  localparam time T = 40ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, sync_pulse, data_req, err_inv;
  logic [3:0] sync_long;
  logic [1:0] data_size;
  int total = 0, bad = 0;
  int sync_cnt = 0, req_cnt = 0;
  logic [1:0] last_size = '0;
  logic [15:0] rx;

  always #2ns clk = ~clk;

  spi_cmd_frontend u_spi_cmd_frontend (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .mosi_i(mosi),
    .miso_o(miso), .sync_pulse_o(sync_pulse), .sync_long_o(sync_long),
    .data_req_o(data_req), .data_size_o(data_size), .err_invalid_o(err_inv)
  );

  always @(posedge clk) begin
    if (sync_pulse) sync_cnt <= sync_cnt + 1;
    if (data_req) begin req_cnt <= req_cnt + 1; last_size <= data_size; end
  end

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] tx, input int nbits, output logic [15:0] r);
    r = '0;
    cs_n = 1'b0;
    mosi = tx[15];
    #T;
    for (int i = 0; i < nbits; i++) begin
      r = {r[14:0], miso};
      sclk = 1'b1;
      #T;
      sclk = 1'b0;
      if (i < 15) mosi = tx[14-i];
      #T;
    end
    cs_n = 1'b1;
    #(4*T);
  endtask

  task automatic frame(input logic [15:0] tx, output logic [15:0] r);
    xfer(tx, 16, r);
  endtask

  task automatic t_reset;
    chk("R1 err after reset", {15'b0, err_inv}, 16'h0);
    frame(16'hE000, rx); chk("R1 first reply", rx, 16'h0000);
  endtask

  task automatic t_nop;
    frame(16'hE000, rx); chk("R2 nop reply lag", rx, 16'hE000);
  endtask

  task automatic t_write;
    frame(16'h1000, rx);
    frame(16'h5ABC, rx); chk("R4 write echo", rx, 16'h1000);
    frame(16'hE000, rx); chk("R4 write readback", rx, 16'h5ABC);
  endtask

  task automatic t_read;
    frame(16'h2000, rx);
    frame(16'h5000, rx); chk("R5 read echo", rx, 16'h2000);
    frame(16'hE000, rx); chk("R5 read data", rx, 16'h5ABC);
  endtask

  task automatic t_sync;
    int s0;
    frame(16'h1000, rx);
    frame(16'h0005, rx);
    frame(16'hE000, rx); chk("R7 reg0 readback", rx, 16'h0005);
    chk("R7 long bits", {12'b0, sync_long}, 16'h0005);
    s0 = sync_cnt;
    frame(16'h3000, rx);
    chk("R7 sync strobe count", 16'(sync_cnt - s0), 16'd1);
    frame(16'hE000, rx); chk("R7 sync echo", rx, 16'h3000);
  endtask

  task automatic t_getdata;
    logic [15:0] ops [4] = '{16'h4000, 16'h5000, 16'h7000, 16'h8000};
    for (int k = 0; k < 4; k++) begin
      int r0 = req_cnt;
      frame(ops[k], rx);
      chk("R8 request strobe", 16'(req_cnt - r0), 16'd1);
      chk("R8 size code", {14'b0, last_size}, 16'(k));
      if (k > 0) chk("R8 echo", rx, ops[k-1]);
    end
    frame(16'hE000, rx); chk("R8 last echo", rx, 16'h8000);
  endtask

  task automatic t_invalid;
    int s0 = sync_cnt;
    frame(16'h3001, rx);
    chk("R3 no strobe on bad low bits", 16'(sync_cnt - s0), 16'd0);
    chk("R3 flag set", {15'b0, err_inv}, 16'h1);
    frame(16'h6000, rx); chk("R3 zero reply", rx, 16'h0000);
    frame(16'hE000, rx); chk("R3 zero reply unknown op", rx, 16'h0000);
  endtask

  task automatic t_status;
    frame(16'h2000, rx);
    frame(16'hF000, rx);
    frame(16'hE000, rx); chk("R12 status read", rx, 16'hF001);
    chk("R12 flag cleared by read", {15'b0, err_inv}, 16'h0);
    frame(16'h1000, rx);
    frame(16'hF123, rx);
    frame(16'hE000, rx); chk("R12 status write readback", rx, 16'hF000);
    chk("R12 status write ignored", {15'b0, err_inv}, 16'h0);
  endtask

  task automatic t_third;
    int r0;
    frame(16'h1000, rx);
    frame(16'h0123, rx);
    r0 = req_cnt;
    frame(16'h4000, rx); chk("R6 payload readback", rx, 16'h0123);
    chk("R6 no request after write", 16'(req_cnt - r0), 16'd0);
    chk("R6 flag set", {15'b0, err_inv}, 16'h1);
    frame(16'hE000, rx); chk("R6 zero reply", rx, 16'h0000);
  endtask

  task automatic t_comm;
    xfer(16'h2000, 12, rx);
    frame(16'hE000, rx); chk("R9 zero after short frame", rx, 16'h0000);
    chk("R9 flag unchanged", {15'b0, err_inv}, 16'h1);
    frame(16'hE000, rx); chk("R9 sequence aborted", rx, 16'hE000);
  endtask

  task automatic t_noclk;
    int r0 = req_cnt;
    frame(16'h7000, rx);
    cs_n = 1'b0; #T; cs_n = 1'b1; #(4*T);
    chk("R10 no extra strobe", 16'(req_cnt - r0), 16'd1);
    frame(16'hE000, rx); chk("R10 pending reply kept", rx, 16'h7000);
  endtask

  task automatic t_swreset;
    frame(16'hF000, rx);
    frame(16'hE000, rx); chk("R11 zero reply", rx, 16'h0000);
    chk("R11 flag cleared", {15'b0, err_inv}, 16'h0);
    chk("R11 reg0 cleared", {12'b0, sync_long}, 16'h0);
    frame(16'h2000, rx);
    frame(16'h5000, rx);
    frame(16'hE000, rx); chk("R11 reg5 cleared", rx, 16'h5000);
  endtask

  initial begin
    #50ns rst_n = 1'b1;
    #100ns;
    t_reset();
    t_nop();
    t_write();
    t_read();
    t_sync();
    t_getdata();
    t_invalid();
    t_status();
    t_third();
    t_comm();
    t_noclk();
    t_swreset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #600us;
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule